// File: doc/BRIEF.md
# Inbound PCI Target Claim and Latency-Disconnect Gate

This block sits on the target side of a host bridge. For each inbound bus cycle, it decides whether the bridge claims the cycle or lets it go unanswered. Each cycle arrives as a decoded request: a command class (memory, I/O, configuration or other) and a hit flag from an external region-range comparator. The decision uses three enable bits: memory acceptance, I/O acceptance and configuration refusal. A request that is not claimed gets a silent ignore pulse. The master then sees no response and falls through to master-abort. No target-abort is ever produced.

After a claim, the block counts data-phase cycles against a per-transaction budget. The budget is loaded from the latency timer value when the request is accepted. When latency disconnect is enabled and the budget runs out, the block raises a disconnect indication. Disconnect stays high until the transaction ends. The enable bits and the timer are sampled only when a request is accepted. Changes made during a transaction therefore apply only to the next one.

Requests use a valid/ready handshake. `req_ready` is high only while no claimed transaction is open. A request is taken in a cycle where `req_valid` and `req_ready` are both high. The source must hold `req_valid` and its fields stable until that cycle. Back-pressure lasts from acceptance of a claimed request until the cycle after `xfer_end`.

Top module: `pci_tgt_gate`

## Requirements
- R1: A memory request (`req_cmd` = 2'b00) is claimed only when `ctl_mem_en` is 1 and `req_hit` is 1; otherwise it is ignored.
- R2: An I/O request (`req_cmd` = 2'b01) is claimed whenever `ctl_io_en` is 1, regardless of `req_hit`, and ignored when it is 0.
- R3: A configuration request (`req_cmd` = 2'b10) is claimed when `ctl_cfg_dis` is 0 and ignored when it is 1, regardless of `req_hit`.
- R4: A request with `req_cmd` = 2'b11 is never claimed. For every accepted request, exactly one of `claim` and `ignore` is high, for exactly one cycle, in the cycle after acceptance.
- R5: While reset is applied and in the first cycle after it, `claim`, `ignore` and `disconnect` are 0 and `req_ready` is 1. With all enable bits at 0, configuration requests are claimed and memory and I/O requests are not.
- R6: With `ctl_lat_disc_en` = 1 and timer value T > 0 at acceptance, the budget drops by one on each cycle with `dphase` high. `disconnect` rises in the cycle after the T-th such cycle, then stays high until the transaction ends.
- R7: A transaction accepted with a timer value of 0, or with `ctl_lat_disc_en` = 0, never raises `disconnect`.
- R8: Changes to the enable bits or `lat_timer` after acceptance do not alter the claim decision or the disconnect timing of the open transaction.
- R9: `req_ready` is 0 from the cycle after a claimed request is accepted until `xfer_end` is seen. In the cycle after `xfer_end`, `req_ready` is 1 and `disconnect` is 0.
- R10: An ignored request leaves no transaction open: `req_ready` is 1 in the cycle the `ignore` pulse is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Inbound cycle request present |
| req_ready | output | 1 | Gate can accept a request (no claimed transaction open) |
| req_cmd | input | 2 | Command class: 00 memory, 01 I/O, 10 configuration, 11 other |
| req_hit | input | 1 | Address fell inside a configured region |
| ctl_mem_en | input | 1 | Accept memory cycles in configured regions |
| ctl_io_en | input | 1 | Accept all I/O cycles |
| ctl_cfg_dis | input | 1 | Refuse configuration cycles |
| ctl_lat_disc_en | input | 1 | Enable latency-budget disconnect |
| lat_timer | input | LAT_W | Latency budget in data-phase cycles |
| dphase | input | 1 | A data phase completes this cycle |
| xfer_end | input | 1 | The open transaction ends this cycle |
| claim | output | 1 | One-cycle pulse: request claimed |
| ignore | output | 1 | One-cycle pulse: request left unanswered |
| disconnect | output | 1 | Budget expired; disconnect the master |

## Verification
The bench builds the block with LAT_W = 4, so the timer spans 0 to 15. Random transactions can then reach every budget value, including the all-ones maximum, and can run data phases past expiry within a few dozen cycles. The same width lets the zero-budget case and the last-step transition from one to zero appear many times per run. Directed cases cover the all-zero reset enables, the other command class with every enable set, and changes to the enables and timer in the middle of a transaction.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    CMD_MEM   = 2'b00,
    CMD_IO    = 2'b01,
    CMD_CFG   = 2'b10,
    CMD_OTHER = 2'b11
  } tcmd_e;

  typedef struct packed {
    logic lat_disc_en;
    logic cfg_dis;
    logic io_en;
    logic mem_en;
  } tctl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } tstate_e;

endpackage

// File: rtl/pci_tgt_decide.sv
module pci_tgt_decide
  import pci_tgt_pkg::*;
(
  input  tcmd_e cmd,
  input  logic  hit,
  input  tctl_t ctl,
  output logic  take
);

  always_comb begin
    unique case (cmd)
      CMD_MEM:   take = ctl.mem_en & hit;
      CMD_IO:    take = ctl.io_en;
      CMD_CFG:   take = ~ctl.cfg_dis;
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/pci_tgt_latcnt.sv
module pci_tgt_latcnt #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  input  logic             arm_en,
  input  logic             step,
  input  logic             clear,
  output logic             expired
);

  localparam logic [LAT_W-1:0] ONE  = LAT_W'(1);
  localparam logic [LAT_W-1:0] ZERO = '0;

  logic [LAT_W-1:0] cnt_q;
  logic             armed_q;
  logic             exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= ZERO;
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      armed_q <= arm_en && (load_val != ZERO);
      exp_q   <= 1'b0;
    end else if (clear) begin
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
    end else if (step && cnt_q != ZERO) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE && armed_q) exp_q <= 1'b1;
    end
  end

  assign expired = exp_q;

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
  import pci_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic take,
  input  logic dphase,
  input  logic xfer_end,
  output logic req_ready,
  output logic accept,
  output logic step,
  output logic clear,
  output logic claim_p,
  output logic ignore_p
);

  tstate_e st_q;
  logic    claim_q;
  logic    ignore_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign clear     = (st_q == ST_BUSY) && xfer_end;
  assign step      = (st_q == ST_BUSY) && dphase && !xfer_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      claim_q  <= 1'b0;
      ignore_q <= 1'b0;
    end else begin
      claim_q  <= accept && take;
      ignore_q <= accept && !take;
      unique case (st_q)
        ST_IDLE: if (accept && take) st_q <= ST_BUSY;
        ST_BUSY: if (xfer_end)       st_q <= ST_IDLE;
        default:                     st_q <= ST_IDLE;
      endcase
    end
  end

  assign claim_p  = claim_q;
  assign ignore_p = ignore_q;

endmodule

// File: rtl/pci_tgt_gate.sv
module pci_tgt_gate
  import pci_tgt_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_cmd,
  input  logic             req_hit,
  input  logic             ctl_mem_en,
  input  logic             ctl_io_en,
  input  logic             ctl_cfg_dis,
  input  logic             ctl_lat_disc_en,
  input  logic [LAT_W-1:0] lat_timer,
  input  logic             dphase,
  input  logic             xfer_end,
  output logic             claim,
  output logic             ignore,
  output logic             disconnect
);

  tctl_t ctl;
  logic  take;
  logic  accept;
  logic  step;
  logic  clear;

  assign ctl = '{lat_disc_en: ctl_lat_disc_en, cfg_dis: ctl_cfg_dis,
                 io_en: ctl_io_en, mem_en: ctl_mem_en};

  pci_tgt_decide u_decide (
    .cmd  (tcmd_e'(req_cmd)),
    .hit  (req_hit),
    .ctl  (ctl),
    .take (take)
  );

  pci_tgt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .take      (take),
    .dphase    (dphase),
    .xfer_end  (xfer_end),
    .req_ready (req_ready),
    .accept    (accept),
    .step      (step),
    .clear     (clear),
    .claim_p   (claim),
    .ignore_p  (ignore)
  );

  pci_tgt_latcnt #(.LAT_W(LAT_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept && take),
    .load_val (lat_timer),
    .arm_en   (ctl.lat_disc_en),
    .step     (step),
    .clear    (clear),
    .expired  (disconnect)
  );

endmodule

// File: rtl/pci_tgt_gate_chk.sv
module pci_tgt_gate_chk #(
  parameter int LAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_cmd,
  input logic             req_hit,
  input logic             ctl_mem_en,
  input logic             ctl_io_en,
  input logic             ctl_cfg_dis,
  input logic             ctl_lat_disc_en,
  input logic [LAT_W-1:0] lat_timer,
  input logic             dphase,
  input logic             xfer_end,
  input logic             claim,
  input logic             ignore,
  input logic             disconnect
);

  logic acc;
  logic quiet_q;
  assign acc = req_valid && req_ready;

  // R7: tracks transactions that must never disconnect
  always_ff @(posedge clk) begin
    if (!rst_n)                      quiet_q <= 1'b0;
    else if (acc)                    quiet_q <= (lat_timer == '0) || !ctl_lat_disc_en;
    else if (!req_ready && xfer_end) quiet_q <= 1'b0;
  end

  p_mem_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_cmd == 2'b00 && !(ctl_mem_en && req_hit)) |=> ignore);

  p_io_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_cmd == 2'b01) |=> (claim == $past(ctl_io_en)));

  p_cfg_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_cmd == 2'b10) |=> (claim == !$past(ctl_cfg_dis)));

  p_other_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_cmd == 2'b11) |=> (ignore && !claim));

  p_one_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> $onehot({claim, ignore}));

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({claim, ignore}) <= 1);

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (claim || ignore) |=> !(claim || ignore) || $past(acc));

  p_disc_after_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disconnect) |-> $past(dphase));

  p_disc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disconnect && !xfer_end) |=> disconnect);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_q |-> !disconnect);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> !req_ready);

  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && xfer_end) |=> (req_ready && !disconnect));

  p_disc_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |-> !req_ready);

  p_ready_ign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ignore |-> req_ready);

endmodule

bind pci_tgt_gate pci_tgt_gate_chk #(.LAT_W(LAT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_cmd         (req_cmd),
  .req_hit         (req_hit),
  .ctl_mem_en      (ctl_mem_en),
  .ctl_io_en       (ctl_io_en),
  .ctl_cfg_dis     (ctl_cfg_dis),
  .ctl_lat_disc_en (ctl_lat_disc_en),
  .lat_timer       (lat_timer),
  .dphase          (dphase),
  .xfer_end        (xfer_end),
  .claim           (claim),
  .ignore          (ignore),
  .disconnect      (disconnect)
);

// File: tb/sim_pci_tgt_gate.sv
`timescale 1ns/1ps
module sim_pci_tgt_gate;

  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_cmd = 2'b00;
  logic          req_hit = 1'b0;
  logic          ctl_mem_en = 1'b0;
  logic          ctl_io_en = 1'b0;
  logic          ctl_cfg_dis = 1'b0;
  logic          ctl_lat_disc_en = 1'b0;
  logic [LW-1:0] lat_timer = '0;
  logic          dphase = 1'b0;
  logic          xfer_end = 1'b0;
  logic          claim;
  logic          ignore;
  logic          disconnect;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pci_tgt_gate #(.LAT_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_hit(req_hit), .ctl_mem_en(ctl_mem_en),
    .ctl_io_en(ctl_io_en), .ctl_cfg_dis(ctl_cfg_dis),
    .ctl_lat_disc_en(ctl_lat_disc_en), .lat_timer(lat_timer),
    .dphase(dphase), .xfer_end(xfer_end), .claim(claim), .ignore(ignore),
    .disconnect(disconnect)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ctl bits: [0] memory enable, [1] I/O enable, [2] config refuse, [3] latency disconnect enable
  function automatic bit exp_take(input logic [1:0] c, input logic h, input logic [3:0] k);
    case (c)
      2'b00:   return k[0] && h;
      2'b01:   return k[1];
      2'b10:   return !k[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cmd_tag(input logic [1:0] c);
    case (c)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic bit exp_disc(input logic [3:0] k, input int t, input int n);
    return k[3] && (t != 0) && (n >= t);
  endfunction

  task automatic set_ctl(input logic [3:0] k);
    ctl_mem_en      = k[0];
    ctl_io_en       = k[1];
    ctl_cfg_dis     = k[2];
    ctl_lat_disc_en = k[3];
  endtask

  task automatic run_txn(input logic [1:0] c, input logic h, input logic [3:0] k,
                         input int t, input int nd, input bit perturb);
    bit    tk;
    string dt;
    tk = exp_take(c, h, k);
    @(negedge clk);
    check("R9", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_cmd = c; req_hit = h; set_ctl(k); lat_timer = LW'(t);
    @(negedge clk);
    req_valid = 1'b0;
    check(cmd_tag(c), "claim", int'(claim), int'(tk));
    check("R4", "ignore", int'(ignore), int'(!tk));
    if (!tk) begin
      check("R10", "ready at ignore", int'(req_ready), 1);
      return;
    end
    check("R9", "ready while open", int'(req_ready), 0);
    check("R6", "disconnect at claim", int'(disconnect), 0);
    if (perturb) begin
      set_ctl(~k);
      lat_timer = LW'($urandom_range(0, 15));
    end
    dt = perturb ? "R8" : ((k[3] && t != 0) ? "R6" : "R7");
    for (int i = 1; i <= nd; i++) begin
      dphase = 1'b1;
      @(negedge clk);
      check(dt, "disconnect", int'(disconnect), int'(exp_disc(k, t, i)));
      check(dt, "claim pulse gone", int'(claim), 0);
    end
    dphase = 1'b0;
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    check("R9", "ready after end", int'(req_ready), 1);
    check("R9", "disconnect after end", int'(disconnect), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R5", "ready in reset", int'(req_ready), 1);
    check("R5", "claim in reset", int'(claim), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5", "claim after reset", int'(claim), 0);
    check("R5", "ignore after reset", int'(ignore), 0);
    check("R5", "disconnect after reset", int'(disconnect), 0);
    check("R5", "ready after reset", int'(req_ready), 1);

    // R5: all-zero enables
    run_txn(2'b10, 1'b0, 4'b0000, 3, 2, 1'b0);
    run_txn(2'b00, 1'b1, 4'b0000, 3, 0, 1'b0);
    run_txn(2'b01, 1'b1, 4'b0000, 3, 0, 1'b0);
    // R4: other class with everything enabled
    run_txn(2'b11, 1'b1, 4'b1011, 5, 0, 1'b0);
    // R1: memory miss
    run_txn(2'b00, 1'b0, 4'b1001, 2, 0, 1'b0);
    // R6: expiry at 1 and at maximum, run past expiry
    run_txn(2'b00, 1'b1, 4'b1001, 1, 4, 1'b0);
    run_txn(2'b01, 1'b0, 4'b1010, 15, 18, 1'b0);
    // R7: zero budget, and disabled disconnect
    run_txn(2'b10, 1'b0, 4'b1000, 0, 10, 1'b0);
    run_txn(2'b10, 1'b0, 4'b0000, 2, 6, 1'b0);
    // R8: mid-transaction changes
    run_txn(2'b10, 1'b0, 4'b1000, 4, 7, 1'b1);
    run_txn(2'b01, 1'b1, 4'b0010, 2, 5, 1'b1);

    for (int n = 0; n < 400; n++) begin
      run_txn(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              4'($urandom_range(0, 15)), $urandom_range(0, 15),
              $urandom_range(0, 18), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule